// File: doc/BRIEF.md
# Edge-Coded Level Link with Failsafe Watchdog

This block carries a single logic level from a sending side to a receiving side without ever transmitting the level itself. The sending half first cleans the input: an optional glitch filter accepts a new level only after that level has been held for a programmable number of clock cycles. Each accepted change becomes a one-cycle event on a two-wire event pair. A set event stands for a rising change and a reset event for a falling one. Between changes, the sender repeats the current level on the same pair at a fixed interval, so the receiver keeps getting a refresh while the input is static.

The receiving half rebuilds the level in a set/reset storage bit. It also runs a watchdog that every event restarts. If no event arrives within the timeout window, the receiver decides that the sending side is dead or undriven, forces its output high and raises a failsafe flag. The next valid event clears that state. The event pair is brought out to the top level, so the two halves can sit on either side of an isolation boundary or a long route, and a bench can cut or corrupt the link.

The filter length, refresh period and timeout are parameters counted in clock cycles; at 50 MHz, a 4 µs window is 200 cycles. A run-time input bypasses the filter, which gives lower latency and removes glitch rejection.

Top module: `edge_link_failsafe`

## Requirements
- R1: While reset is held, and after it is released, `dout` is 1 and `failsafe_o` is 1 until the first event reaches the receiver. The sender issues an event on the first clock edge after reset is released: a reset event (`tx_rst_o`=1) when the filtered level is low.
- R2: With `filt_bypass`=0, an input pulse held for fewer than FILT_CYCLES consecutive sampled cycles produces no event of its polarity and leaves `dout` unchanged.
- R3: With `filt_bypass`=0, an input level held for at least FILT_CYCLES sampled cycles reaches `dout` on the (FILT_CYCLES+3)-th falling clock edge after the input changes. The change is driven just after a falling edge.
- R4: With `filt_bypass`=1, an input level held for a single cycle reaches `dout` on the 4th falling clock edge after it is driven.
- R5: A rising filtered level produces a set event (`tx_set_o`), and a falling one produces a reset event (`tx_rst_o`). The sender never asserts both in the same cycle.
- R6: With the input held constant, the sender emits a refresh event of the current level at least every REFRESH_CYCLES cycles. A connected link therefore holds a DC level indefinitely with `failsafe_o`=0.
- R7: When no event reaches the receiver for TIMEOUT_CYCLES consecutive clock edges, `failsafe_o` becomes 1 and `dout` becomes 1 on the TIMEOUT_CYCLES-th edge after the last event. Both stay so while no event arrives.
- R8: The first event after a timeout clears `failsafe_o` on the next edge. `dout` then shows the stored level again.
- R9: `rx_set_i` and `rx_rst_i` asserted together keep the stored level unchanged, but still restart the watchdog and clear `failsafe_o`.
- R10: A lone `rx_set_i` stores 1 and a lone `rx_rst_i` stores 0. The stored value appears on `dout` one edge later when not in failsafe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Level to be carried |
| filt_bypass | input | 1 | 1 removes the glitch filter from the path |
| tx_set_o | output | 1 | Sender set event (rising or high refresh) |
| tx_rst_o | output | 1 | Sender reset event (falling or low refresh) |
| rx_set_i | input | 1 | Receiver set event |
| rx_rst_i | input | 1 | Receiver reset event |
| dout | output | 1 | Rebuilt level, forced high in failsafe |
| failsafe_o | output | 1 | 1 while the watchdog has expired |

## Verification
Two functions can land in the same cycle. A level change can coincide with a scheduled refresh, and set and reset can arrive at the receiver together. Random hold lengths make edges fall at every phase of the refresh period. A reference model of the filtered level, delayed by the link pipeline, is compared with `dout` on every cycle, and a gap counter bounds the spacing between events. Coincident set and reset are injected directly on a cut link: the stored level must hold while the watchdog restarts. A per-cycle watchdog model then confirms the exact timeout edge.

// File: rtl/elink_pkg.sv
package elink_pkg;

   // Event encoding on the link pair: bit 0 = set, bit 1 = reset.
   typedef enum logic [1:0] {
      EV_NONE = 2'b00,
      EV_SET  = 2'b01,
      EV_RST  = 2'b10,
      EV_BOTH = 2'b11
   } link_ev_e;

   function automatic link_ev_e ev_for_level(input logic lvl);
      return lvl ? EV_SET : EV_RST;
   endfunction

endpackage

// File: rtl/elink_glitch_filter.sv
module elink_glitch_filter #(
   parameter int FILT_CYCLES    = 4,
   parameter bit FILTER_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic bypass,
   output logic level
);

   logic din_q;
   logic filt_out;

   always_ff @(posedge clk) begin
      if (!rst_n) din_q <= 1'b0;
      else        din_q <= din;
   end

   generate
      if (FILTER_PRESENT && (FILT_CYCLES > 1)) begin : g_counter
         localparam int CW = $clog2(FILT_CYCLES);
         logic [CW-1:0] run_cnt;
         logic          take;

         assign take     = (din_q != level) && (run_cnt == CW'(FILT_CYCLES - 1));
         assign filt_out = take ? din_q : level;

         always_ff @(posedge clk) begin
            if (!rst_n)                      run_cnt <= '0;
            else if (bypass || din_q == level) run_cnt <= '0;
            else if (take)                   run_cnt <= '0;
            else                             run_cnt <= run_cnt + 1'b1;
         end
      end else begin : g_pass
         assign filt_out = din_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) level <= 1'b0;
      else        level <= bypass ? din_q : filt_out;
   end

   generate
      if (FILTER_PRESENT && (FILT_CYCLES > 1)) begin : g_chk
         AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass && din_q == level) |=> $stable(level)); // R2
      end
   endgenerate

endmodule

// File: rtl/elink_tx.sv
module elink_tx
   import elink_pkg::*;
#(
   parameter int REFRESH_CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic set_o,
   output logic rst_o
);

   localparam int RW = $clog2(REFRESH_CYCLES + 1);

   logic          lvl_d;
   logic          first;
   logic [RW-1:0] ref_cnt;
   logic          fire;
   link_ev_e      ev_q;

   assign fire = first || (level != lvl_d) || (ref_cnt == RW'(REFRESH_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_d   <= 1'b0;
         first   <= 1'b1;
         ref_cnt <= '0;
         ev_q    <= EV_NONE;
      end else begin
         lvl_d   <= level;
         first   <= 1'b0;
         ref_cnt <= fire ? '0 : ref_cnt + 1'b1;
         ev_q    <= fire ? ev_for_level(level) : EV_NONE;
      end
   end

   assign set_o = ev_q[0];
   assign rst_o = ev_q[1];

   // Independent spacing monitor for the refresh guarantee.
   logic [RW:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n)                gap <= '0;
      else if (ev_q == EV_NONE)  gap <= gap + 1'b1;
      else                       gap <= '0;
   end

   AST_TX_REFRESH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      gap < (RW+1)'(REFRESH_CYCLES)); // R6
   AST_TX_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (level && !lvl_d) |=> set_o); // R5
   AST_TX_FALL_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (!level && lvl_d) |=> rst_o); // R5
   AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_o, rst_o})); // R5

endmodule

// File: rtl/elink_rx.sv
module elink_rx
   import elink_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rst_i,
   output logic dout,
   output logic failsafe
);

   localparam int TW = $clog2(TIMEOUT_CYCLES);

   link_ev_e      ev;
   logic          q;
   logic [TW-1:0] timer;

   assign ev = link_ev_e'({rst_i, set_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q        <= 1'b1;
         failsafe <= 1'b1;
         timer    <= '0;
      end else begin
         case (ev)
            EV_SET:  q <= 1'b1;
            EV_RST:  q <= 1'b0;
            default: q <= q;
         endcase
         if (ev != EV_NONE) begin
            timer    <= '0;
            failsafe <= 1'b0;
         end else if (timer == TW'(TIMEOUT_CYCLES - 1)) begin
            failsafe <= 1'b1;
         end else begin
            timer <= timer + 1'b1;
         end
      end
   end

   assign dout = failsafe | q;

   AST_RX_SET_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !rst_i) |=> (dout && !failsafe)); // R10
   AST_RX_RST_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_i && !set_i) |=> (!dout && !failsafe)); // R10
   AST_RX_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && rst_i) |=> $stable(q)); // R9
   AST_RX_FS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i || rst_i) |=> !failsafe); // R8
   AST_RX_FS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (failsafe && !set_i && !rst_i) |=> (failsafe && dout)); // R7

endmodule

// File: rtl/edge_link_failsafe.sv
module edge_link_failsafe #(
   parameter int FILT_CYCLES    = 4,
   parameter bit FILTER_PRESENT = 1'b1,
   parameter int REFRESH_CYCLES = 50,
   parameter int TIMEOUT_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic filt_bypass,
   output logic tx_set_o,
   output logic tx_rst_o,
   input  logic rx_set_i,
   input  logic rx_rst_i,
   output logic dout,
   output logic failsafe_o
);

   generate
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("FILT_CYCLES must be at least 1");
      end
      if (REFRESH_CYCLES < 2) begin : g_bad_ref
         $error("REFRESH_CYCLES must be at least 2");
      end
      if (REFRESH_CYCLES * 2 > TIMEOUT_CYCLES) begin : g_bad_ratio
         $error("REFRESH_CYCLES must be at most half of TIMEOUT_CYCLES");
      end
   endgenerate

   logic level;

   elink_glitch_filter #(
      .FILT_CYCLES    (FILT_CYCLES),
      .FILTER_PRESENT (FILTER_PRESENT)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (din),
      .bypass (filt_bypass),
      .level  (level)
   );

   elink_tx #(
      .REFRESH_CYCLES (REFRESH_CYCLES)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .level (level),
      .set_o (tx_set_o),
      .rst_o (tx_rst_o)
   );

   elink_rx #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (rx_set_i),
      .rst_i    (rx_rst_i),
      .dout     (dout),
      .failsafe (failsafe_o)
   );

endmodule

// File: tb/sim_edge_link_failsafe.sv
module sim_edge_link_failsafe;

   localparam int N     = 4;
   localparam int REF   = 50;
   localparam int TO    = 200;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0;
   logic bypass = 1'b0;
   logic cut = 1'b0;
   logic inj_set = 1'b0;
   logic inj_rst = 1'b0;
   logic tx_set, tx_rst, rx_set, rx_rst, dout, fs;

   always #10 clk = ~clk;

   assign rx_set = (tx_set & ~cut) | inj_set;
   assign rx_rst = (tx_rst & ~cut) | inj_rst;

   edge_link_failsafe #(
      .FILT_CYCLES(N), .FILTER_PRESENT(1'b1),
      .REFRESH_CYCLES(REF), .TIMEOUT_CYCLES(TO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .filt_bypass(bypass),
      .tx_set_o(tx_set), .tx_rst_o(tx_rst),
      .rx_set_i(rx_set), .rx_rst_i(rx_rst),
      .dout(dout), .failsafe_o(fs)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;
   bit started = 0;

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Reference model built from the requirements.
   logic hist [N];
   logic lvl_m, lvl_p1, lvl_p2, qm;
   int   since, gap, settle;
   bit   saw_set;

   function automatic logic run_done(input int n, input logic cur, output logic nv);
      logic v;
      v = hist[0];
      for (int i = 1; i < n; i++) if (hist[i] !== v) return 1'b0;
      nv = v;
      return (v !== cur);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc >= LIMIT && !done) begin
         fails++;
         $display("FAIL watchdog: got running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
      if (!rst_n) begin
         for (int i = 0; i < N; i++) hist[i] = 1'b0;
         lvl_m = 0; lvl_p1 = 0; lvl_p2 = 0; qm = 1;
         since = TO; gap = 0; settle = REF + N + 8;
      end else begin
         logic nv;
         if (rx_set | rx_rst) begin
            since = 0;
            if (rx_set && !rx_rst) qm = 1'b1;
            else if (rx_rst && !rx_set) qm = 1'b0;
         end else if (since < TO) since++;
         if (tx_set | tx_rst) begin
            if (tx_set) saw_set = 1;
            tests++;
            if (gap >= REF) begin
               fails++;
               $display("FAIL R6: got gap %0d expected below %0d", gap, REF);
            end
            gap = 0;
         end else gap++;
         lvl_p2 = lvl_p1;
         lvl_p1 = lvl_m;
         nv = lvl_m;
         if (run_done(bypass ? 1 : N, lvl_m, nv)) lvl_m = nv;
         for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = din;
         if (cut | inj_set | inj_rst) settle = REF + N + 8;
         else if (settle > 0) settle--;
      end
   end

   always @(negedge clk) begin
      if (rst_n && started) begin
         logic fs_exp;
         fs_exp = (since >= TO);
         check("R7", fs, fs_exp);
         check("R10", dout, fs_exp ? 1'b1 : qm);
         check("R5", tx_set & tx_rst, 1'b0);
         if (!fs_exp && settle == 0) check("R3", dout, lvl_p2);
      end
   end

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      // R1: reset state
      wait_neg(3);
      check("R1", dout, 1'b1);
      check("R1", fs, 1'b1);
      rst_n = 1'b1;
      started = 1;
      wait_neg(1);
      check("R1", tx_rst, 1'b1);
      wait_neg(2);
      check("R1", fs, 1'b0);

      // R2: short glitch rejected by the filter
      wait_neg(REF + 10);
      saw_set = 0;
      din = 1'b1;
      wait_neg(N - 1);
      din = 1'b0;
      wait_neg(3 * REF);
      check("R2", saw_set, 1'b0);
      check("R2", dout, 1'b0);

      // R3: exact latency through the filter
      din = 1'b1;
      wait_neg(N + 2);
      check("R3", dout, 1'b0);
      wait_neg(1);
      check("R3", dout, 1'b1);

      // R4: bypass lets a one-cycle pulse through
      wait_neg(20);
      bypass = 1'b1;
      wait_neg(10);
      din = 1'b0;
      wait_neg(1);
      din = 1'b1;
      wait_neg(2);
      check("R4", dout, 1'b1);
      wait_neg(1);
      check("R4", dout, 1'b0);
      wait_neg(1);
      check("R4", dout, 1'b1);

      // R6: long DC hold kept alive by refresh
      wait_neg(5);
      bypass = 1'b0;
      wait_neg(3000);
      check("R6", fs, 1'b0);
      check("R6", dout, 1'b1);

      // R7..R10: cut link, timeout, recovery, injected events
      din = 1'b0;
      wait_neg(N + 5);
      cut = 1'b1;
      wait_neg(TO + 3);
      check("R7", fs, 1'b1);
      check("R7", dout, 1'b1);
      inj_rst = 1'b1;
      wait_neg(1);
      inj_rst = 1'b0;
      check("R8", fs, 1'b0);
      check("R8", dout, 1'b0);
      inj_set = 1'b1; inj_rst = 1'b1;
      wait_neg(1);
      inj_set = 1'b0; inj_rst = 1'b0;
      check("R9", dout, 1'b0);
      check("R9", fs, 1'b0);
      inj_set = 1'b1;
      wait_neg(1);
      inj_set = 1'b0;
      check("R10", dout, 1'b1);
      wait_neg(TO - 2);
      check("R9", fs, 1'b0);
      wait_neg(3);
      check("R7", fs, 1'b1);
      cut = 1'b0;
      wait_neg(REF + N + 10);
      check("R8", fs, 1'b0);
      check("R8", dout, 1'b0);

      // Random segments: glitches, real edges, mode switches
      for (int s = 0; s < 400; s++) begin
         int len;
         if ($urandom % 8 == 0) begin
            wait_neg(N + 3);
            bypass = $urandom % 2;
            wait_neg(N + 3);
         end
         len = ($urandom % 4 == 0) ? 1 + ($urandom % 120) : 1 + ($urandom % (2 * N + 1));
         din = ~din;
         wait_neg(len);
      end
      wait_neg(REF + 20);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule